// File: doc/BRIEF.md
# Per-Core Private Interrupt State Bank

This block keeps the private interrupt state for one processor core. It covers a set of software-generated interrupts (SGIs) followed by a set of peripheral interrupts (PPIs). The defaults are 16 of each, 32 in all, numbered SGIs first. For every interrupt it holds enable, pending, active, group, group-modifier, a 2-bit trigger configuration and an 8-bit priority. It also holds a per-SGI non-secure access field and a sleep control bit for the core. All of this state is exported as flat vectors so that a priority selector beside the block can pick the next interrupt.

Software reaches the bank through a word-addressed register port. The port carries a secure-access flag. For non-secure requests, priorities are shown through a halved view, and writes to the security-sensitive registers are dropped without any signal. Enable, pending and active each have a set address and a clear address, and both addresses act on the same state bits. Hardware can also raise pending bits: a level on a peripheral input, or an SGI delivery request that passes a group check.

Top module: `pirb_top`

## Requirements
- R1: After synchronous reset, every enable, pending, active, group, group-modifier, trigger and priority bit is 0, `core_asleep` is 1 and `rsp_valid` is 0.
- R2: Word addresses 2/3 set/clear enable, 4/5 set/clear pending and 6/7 set/clear active. A 1 in bit n sets or clears interrupt n, a 0 bit leaves it unchanged, and a read of either address of a pair returns the current state vector.
- R3: Priority words sit at addresses 16 and up, four bytes per word. Interrupt 4w+k lives at bits 8k+7:8k of the word at address 16+w. A secure write stores each byte unchanged, and a secure read returns the stored bytes.
- R4: A non-secure priority write stores 0x80 | (byte >> 1) for every byte of the word.
- R5: A non-secure priority read returns (stored << 1) & 0xFF for every byte.
- R6: The group-modifier register (address 8) and the SGI non-secure access register (address 9, 2 bits per SGI, SGI n at bits 2n+1:2n) accept only secure writes. Non-secure writes to them change nothing, and non-secure reads of them return 0.
- R7: Trigger configuration uses 2 bits per interrupt. Address 10 holds interrupts 0-15 and address 11 holds interrupts 16-31, with interrupt n at bits 2(n mod 16)+1:2(n mod 16). Both sides can read and write it.
- R8: At the wake register (address 0), bit 1 is the sleep request and bit 2 reads back the asleep status. A write sets `core_asleep` to bit 1 of the written data.
- R9: A high level on `ppi_assert[i]` in a cycle sets the pending bit of interrupt NUM_SGI+i at the next edge. It wins over a pending-clear write in the same cycle.
- R10: An SGI request (`sgi_valid`) sets the pending bit of `sgi_id` when `sgi_group` equals that interrupt's group bit. It also does so when the request is non-secure, the interrupt is group 0 and its access field is nonzero. Otherwise the request is dropped.
- R11: A read request gives `rsp_valid` with the data one cycle later. Unmapped addresses read 0 and ignore writes, and a write gives no response.
- R12: The group register (address 1) holds one bit per interrupt, and both sides can read and write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Request comes from the secure side |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ppi_assert | input | NUM_PPI | Peripheral interrupt levels |
| sgi_valid | input | 1 | SGI delivery request |
| sgi_id | input | $clog2(NUM_SGI) | Target SGI number |
| sgi_group | input | 1 | Group of the request |
| sgi_nonsecure | input | 1 | Request comes from the non-secure side |
| out_enable | output | NUM_IRQ | Enable vector |
| out_pending | output | NUM_IRQ | Pending vector |
| out_active | output | NUM_IRQ | Active vector |
| out_group | output | NUM_IRQ | Group vector |
| out_grpmod | output | NUM_IRQ | Group-modifier vector |
| out_prio | output | 8*NUM_IRQ | Priorities, interrupt n at bits 8n+7:8n |
| out_trigger | output | 2*NUM_IRQ | Trigger configuration fields |
| core_asleep | output | 1 | Core is in low-power state |

## Verification
The bench builds the block with its defaults: 16 SGIs and 16 PPIs. With these values every vector fills a full 32-bit register word, the priority bank spans eight words and the trigger bank spans two words, so both ends of each address window are reached. The 16 SGIs give the non-secure access register all 32 of its bits, which lets the bench aim the SGI forwarding rule at a field in the middle of the word. The 16 PPIs put the hardware-raised pending bits in the upper half of the pending word, where they can be told apart from software and SGI effects.

// File: rtl/pirb_pkg.sv
package pirb_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 8;

    localparam logic [ADDR_W-1:0] OFF_WAKE    = 5'd0;
    localparam logic [ADDR_W-1:0] OFF_GROUP   = 5'd1;
    localparam logic [ADDR_W-1:0] OFF_EN_SET  = 5'd2;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 5'd3;
    localparam logic [ADDR_W-1:0] OFF_PND_SET = 5'd4;
    localparam logic [ADDR_W-1:0] OFF_PND_CLR = 5'd5;
    localparam logic [ADDR_W-1:0] OFF_ACT_SET = 5'd6;
    localparam logic [ADDR_W-1:0] OFF_ACT_CLR = 5'd7;
    localparam logic [ADDR_W-1:0] OFF_GRPMOD  = 5'd8;
    localparam logic [ADDR_W-1:0] OFF_NSACC   = 5'd9;
    localparam int                CFG_BASE    = 10;
    localparam int                PRIO_BASE   = 16;

    typedef struct packed {
        logic                valid;
        logic                write;
        logic                secure;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } reg_req_t;

    // Byte stored when the non-secure side writes a priority.
    function automatic logic [PRIO_W-1:0] ns_prio_store(input logic [PRIO_W-1:0] v);
        return 8'h80 | {1'b0, v[PRIO_W-1:1]};
    endfunction

    // Byte shown when the non-secure side reads a priority.
    function automatic logic [PRIO_W-1:0] ns_prio_view(input logic [PRIO_W-1:0] v);
        return {v[PRIO_W-2:0], 1'b0};
    endfunction

    function automatic logic [DATA_W-1:0] ns_word_view(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < DATA_W / PRIO_W; k++)
            r[PRIO_W*k +: PRIO_W] = ns_prio_view(w[PRIO_W*k +: PRIO_W]);
        return r;
    endfunction

endpackage

// File: rtl/pirb_setclr_vec.sv
module pirb_setclr_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_mask[i] || hw_set[i])
                q[i] <= 1'b1;
            else if (clr_mask[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pirb_prio_bank.sv
module pirb_prio_bank
    import pirb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int WORDS  = NUM_IRQ / 4,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    nonsecure,
    output logic [PRIO_W*NUM_IRQ-1:0] prio_flat
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam int LANE = i % 4;
        logic [PRIO_W-1:0] byte_in;
        logic [PRIO_W-1:0] q;
        assign byte_in = wdata[PRIO_W*LANE +: PRIO_W];
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && word_sel == WSEL_W'(i / 4))
                q <= nonsecure ? ns_prio_store(byte_in) : byte_in;
        end
        assign prio_flat[PRIO_W*i +: PRIO_W] = q;
    end
endmodule

// File: rtl/pirb_sgi_gate.sv
module pirb_sgi_gate #(
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                 sgi_valid,
    input  logic [ID_W-1:0]      sgi_id,
    input  logic                 sgi_group,
    input  logic                 sgi_nonsecure,
    input  logic [NUM_SGI-1:0]   group_vec,
    input  logic [2*NUM_SGI-1:0] nsacc_vec,
    output logic [NUM_SGI-1:0]   pend_set
);
    for (genvar i = 0; i < NUM_SGI; i++) begin : g_sgi
        logic hit, grp_match, ns_allowed;
        assign hit        = sgi_valid && (sgi_id == ID_W'(i));
        assign grp_match  = (sgi_group == group_vec[i]);
        assign ns_allowed = sgi_nonsecure && !group_vec[i] && (nsacc_vec[2*i +: 2] != 2'b00);
        assign pend_set[i] = hit && (grp_match || ns_allowed);
    end
endmodule

// File: rtl/pirb_top.sv
module pirb_top
    import pirb_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
    localparam int SGI_ID_W = $clog2(NUM_SGI)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      req_secure,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    input  logic [NUM_PPI-1:0]        ppi_assert,
    input  logic                      sgi_valid,
    input  logic [SGI_ID_W-1:0]       sgi_id,
    input  logic                      sgi_group,
    input  logic                      sgi_nonsecure,
    output logic [NUM_IRQ-1:0]        out_enable,
    output logic [NUM_IRQ-1:0]        out_pending,
    output logic [NUM_IRQ-1:0]        out_active,
    output logic [NUM_IRQ-1:0]        out_group,
    output logic [NUM_IRQ-1:0]        out_grpmod,
    output logic [PRIO_W*NUM_IRQ-1:0] out_prio,
    output logic [2*NUM_IRQ-1:0]      out_trigger,
    output logic                      core_asleep
);
    localparam int PRIO_WORDS = NUM_IRQ / 4;
    localparam int CFG_WORDS  = NUM_IRQ / 16;
    localparam int WSEL_W     = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
    localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(PRIO_BASE);
    localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(PRIO_BASE + PRIO_WORDS);

    reg_req_t req;
    assign req = '{valid: req_valid, write: req_write, secure: req_secure,
                   addr: req_addr, data: req_wdata};

    logic wr;
    assign wr = req.valid && req.write;

    function automatic logic [NUM_IRQ-1:0] wmask(input logic hit, input logic [DATA_W-1:0] d);
        return hit ? d[NUM_IRQ-1:0] : '0;
    endfunction

    // set/clear state vectors
    logic [NUM_SGI-1:0] sgi_set;
    logic [NUM_IRQ-1:0] pend_hw;
    assign pend_hw = {ppi_assert, sgi_set};

    pirb_setclr_vec #(.W(NUM_IRQ)) u_enable (
        .clk(clk), .rst(rst),
        .set_mask(wmask(wr && req.addr == OFF_EN_SET, req.data)),
        .clr_mask(wmask(wr && req.addr == OFF_EN_CLR, req.data)),
        .hw_set('0), .q(out_enable));

    pirb_setclr_vec #(.W(NUM_IRQ)) u_pending (
        .clk(clk), .rst(rst),
        .set_mask(wmask(wr && req.addr == OFF_PND_SET, req.data)),
        .clr_mask(wmask(wr && req.addr == OFF_PND_CLR, req.data)),
        .hw_set(pend_hw), .q(out_pending));

    pirb_setclr_vec #(.W(NUM_IRQ)) u_active (
        .clk(clk), .rst(rst),
        .set_mask(wmask(wr && req.addr == OFF_ACT_SET, req.data)),
        .clr_mask(wmask(wr && req.addr == OFF_ACT_CLR, req.data)),
        .hw_set('0), .q(out_active));

    // priority bank
    logic prio_wr;
    assign prio_wr = wr && (req.addr >= PRIO_LO) && (req.addr < PRIO_HI);

    pirb_prio_bank #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk(clk), .rst(rst),
        .wr_en(prio_wr),
        .word_sel(WSEL_W'(req.addr - PRIO_LO)),
        .wdata(req.data),
        .nonsecure(!req.secure),
        .prio_flat(out_prio));

    // plain registers
    logic [2*NUM_SGI-1:0] nsacc_q;
    logic                 sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_group   <= '0;
            out_grpmod  <= '0;
            nsacc_q     <= '0;
            out_trigger <= '0;
            sleep_q     <= 1'b1;
        end else if (wr) begin
            if (req.addr == OFF_GROUP)
                out_group <= req.data[NUM_IRQ-1:0];
            if (req.addr == OFF_GRPMOD && req.secure)
                out_grpmod <= req.data[NUM_IRQ-1:0];
            if (req.addr == OFF_NSACC && req.secure)
                nsacc_q <= req.data[2*NUM_SGI-1:0];
            if (req.addr == OFF_WAKE)
                sleep_q <= req.data[1];
            for (int w = 0; w < CFG_WORDS; w++)
                if (req.addr == ADDR_W'(CFG_BASE + w))
                    out_trigger[DATA_W*w +: DATA_W] <= req.data;
        end
    end
    assign core_asleep = sleep_q;

    pirb_sgi_gate #(.NUM_SGI(NUM_SGI)) u_sgi (
        .sgi_valid(sgi_valid), .sgi_id(sgi_id), .sgi_group(sgi_group),
        .sgi_nonsecure(sgi_nonsecure),
        .group_vec(out_group[NUM_SGI-1:0]),
        .nsacc_vec(nsacc_q),
        .pend_set(sgi_set));

    // read path
    logic [DATA_W-1:0] rd_word;
    always_comb begin
        rd_word = '0;
        case (req.addr)
            OFF_WAKE:                 rd_word = {29'd0, sleep_q, sleep_q, 1'b0};
            OFF_GROUP:                rd_word = DATA_W'(out_group);
            OFF_EN_SET, OFF_EN_CLR:   rd_word = DATA_W'(out_enable);
            OFF_PND_SET, OFF_PND_CLR: rd_word = DATA_W'(out_pending);
            OFF_ACT_SET, OFF_ACT_CLR: rd_word = DATA_W'(out_active);
            OFF_GRPMOD:               rd_word = req.secure ? DATA_W'(out_grpmod) : '0;
            OFF_NSACC:                rd_word = req.secure ? DATA_W'(nsacc_q) : '0;
            default:                  rd_word = '0;
        endcase
        for (int w = 0; w < CFG_WORDS; w++)
            if (req.addr == ADDR_W'(CFG_BASE + w))
                rd_word = out_trigger[DATA_W*w +: DATA_W];
        for (int w = 0; w < PRIO_WORDS; w++)
            if (req.addr == ADDR_W'(PRIO_BASE + w))
                rd_word = req.secure ? out_prio[DATA_W*w +: DATA_W]
                                     : ns_word_view(out_prio[DATA_W*w +: DATA_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req.valid && !req.write;
            if (req.valid && !req.write)
                rsp_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/pirb_checker.sv
module pirb_checker
    import pirb_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
    localparam int SGI_ID_W = $clog2(NUM_SGI)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic [DATA_W-1:0]         req_wdata,
    input logic                      req_secure,
    input logic                      rsp_valid,
    input logic [NUM_PPI-1:0]        ppi_assert,
    input logic                      sgi_valid,
    input logic [SGI_ID_W-1:0]       sgi_id,
    input logic                      sgi_group,
    input logic [NUM_IRQ-1:0]        out_enable,
    input logic [NUM_IRQ-1:0]        out_pending,
    input logic [NUM_IRQ-1:0]        out_group,
    input logic [NUM_IRQ-1:0]        out_grpmod,
    input logic [PRIO_W*NUM_IRQ-1:0] out_prio,
    input logic                      core_asleep
);
    logic wr;
    assign wr = req_valid && req_write;

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R11

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid); // R11

    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr && req_addr == OFF_EN_CLR) |=> (($past(out_enable) & ~out_enable) == '0)); // R2

    AST_PPI_PENDS: assert property (@(posedge clk) disable iff (rst)
        (ppi_assert != '0) |=>
        ((out_pending[NUM_IRQ-1:NUM_SGI] & $past(ppi_assert)) == $past(ppi_assert))); // R9

    AST_SGI_MATCH_PENDS: assert property (@(posedge clk) disable iff (rst)
        (sgi_valid && sgi_group == out_group[sgi_id]) |=> out_pending[$past(sgi_id)]); // R10

    AST_NS_GRPMOD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr && !req_secure && req_addr == OFF_GRPMOD) |=> $stable(out_grpmod)); // R6

    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr && req_addr == OFF_WAKE) |=> (core_asleep == $past(req_wdata[1]))); // R8

    for (genvar w = 0; w < NUM_IRQ / 4; w++) begin : g_prio_chk
        AST_NS_PRIO_MSB: assert property (@(posedge clk) disable iff (rst)
            (wr && !req_secure && req_addr == ADDR_W'(PRIO_BASE + w)) |=>
            (out_prio[32*w+7] && out_prio[32*w+15] && out_prio[32*w+23] && out_prio[32*w+31])); // R4
    end
endmodule

bind pirb_top pirb_checker #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) u_checker (.*);

// File: tb/tb_pirb_top.sv
module tb_pirb_top;
    import pirb_pkg::*;

    localparam int NUM_SGI = 16;
    localparam int NUM_PPI = 16;
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic                      req_write = 1'b0;
    logic [ADDR_W-1:0]         req_addr = '0;
    logic [DATA_W-1:0]         req_wdata = '0;
    logic                      req_secure = 1'b1;
    logic                      rsp_valid;
    logic [DATA_W-1:0]         rsp_rdata;
    logic [NUM_PPI-1:0]        ppi_assert = '0;
    logic                      sgi_valid = 1'b0;
    logic [3:0]                sgi_id = '0;
    logic                      sgi_group = 1'b0;
    logic                      sgi_nonsecure = 1'b0;
    logic [NUM_IRQ-1:0]        out_enable, out_pending, out_active, out_group, out_grpmod;
    logic [PRIO_W*NUM_IRQ-1:0] out_prio;
    logic [2*NUM_IRQ-1:0]      out_trigger;
    logic                      core_asleep;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pirb_top #(.NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI)) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic sec, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 rsp_valid", 32'(rsp_valid), 32'd1);
        d = rsp_rdata;
    endtask

    task automatic send_sgi(input logic [3:0] id, input logic grp, input logic ns);
        @(negedge clk);
        sgi_valid = 1'b1; sgi_id = id; sgi_group = grp; sgi_nonsecure = ns;
        @(negedge clk);
        sgi_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 enable", out_enable, 32'h0);
        check("R1 pending", out_pending, 32'h0);
        check("R1 active", out_active, 32'h0);
        check("R1 prio lo", out_prio[31:0], 32'h0);
        check("R1 trigger", out_trigger[31:0], 32'h0);
        check("R1 asleep", 32'(core_asleep), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        bus_write(OFF_EN_SET, 32'h0000_00F0, 1'b1);
        check("R2 enable set", out_enable, 32'h0000_00F0);
        bus_write(OFF_EN_SET, 32'h0, 1'b1);
        check("R2 zero write", out_enable, 32'h0000_00F0);
        bus_write(OFF_EN_CLR, 32'h0000_0030, 1'b0);
        check("R2 enable clr", out_enable, 32'h0000_00C0);
        bus_read(OFF_EN_CLR, 1'b1, d);
        check("R2 read clr addr", d, 32'h0000_00C0);
        bus_write(OFF_ACT_SET, 32'h8000_0001, 1'b1);
        bus_write(OFF_ACT_CLR, 32'h0000_0001, 1'b1);
        check("R2 active", out_active, 32'h8000_0000);
        bus_write(OFF_PND_SET, 32'hFFFF_0000, 1'b1);
        bus_read(OFF_PND_SET, 1'b0, d);
        check("R2 pending read", d, 32'hFFFF_0000);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        bus_write(5'd16, 32'h4433_2211, 1'b1);
        bus_write(5'd23, 32'hDEAD_BEEF, 1'b1);
        check("R3 word0", out_prio[31:0], 32'h4433_2211);
        check("R3 irq 0 byte", 32'(out_prio[7:0]), 32'h11);
        check("R3 word7", out_prio[255:224], 32'hDEAD_BEEF);
        bus_read(5'd23, 1'b1, d);
        check("R3 secure read", d, 32'hDEAD_BEEF);
        bus_write(5'd17, 32'h00FE_0402, 1'b0);
        check("R4 ns store", out_prio[63:32], 32'h80FF_8281);
        bus_read(5'd17, 1'b0, d);
        check("R5 ns view", d, 32'h00FE_0402);
        bus_read(5'd16, 1'b0, d);
        check("R5 ns view secure data", d, 32'h8866_4422);
    endtask

    task automatic t_group();
        logic [31:0] d;
        bus_write(OFF_GROUP, 32'h0000_000F, 1'b0);
        check("R12 group out", out_group, 32'h0000_000F);
        bus_read(OFF_GROUP, 1'b0, d);
        check("R12 group read", d, 32'h0000_000F);
    endtask

    task automatic t_secure_only();
        logic [31:0] d;
        bus_write(OFF_GRPMOD, 32'h0000_A5A5, 1'b1);
        check("R6 grpmod secure", out_grpmod, 32'h0000_A5A5);
        bus_write(OFF_GRPMOD, 32'hFFFF_FFFF, 1'b0);
        check("R6 grpmod ns ignored", out_grpmod, 32'h0000_A5A5);
        bus_read(OFF_GRPMOD, 1'b0, d);
        check("R6 grpmod ns read", d, 32'h0);
        bus_read(OFF_GRPMOD, 1'b1, d);
        check("R6 grpmod secure read", d, 32'h0000_A5A5);
        bus_write(OFF_NSACC, 32'hFFFF_FFFF, 1'b0);
        bus_read(OFF_NSACC, 1'b1, d);
        check("R6 nsacc ns ignored", d, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        bus_write(5'd10, 32'h1234_5678, 1'b1);
        bus_write(5'd11, 32'h9ABC_DEF0, 1'b0);
        check("R7 cfg lo", out_trigger[31:0], 32'h1234_5678);
        check("R7 cfg hi", out_trigger[63:32], 32'h9ABC_DEF0);
        bus_read(5'd11, 1'b1, d);
        check("R7 cfg read", d, 32'h9ABC_DEF0);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        bus_read(OFF_WAKE, 1'b1, d);
        check("R8 wake reset read", d, 32'h6);
        bus_write(OFF_WAKE, 32'h0, 1'b0);
        check("R8 awake", 32'(core_asleep), 32'd0);
        bus_read(OFF_WAKE, 1'b1, d);
        check("R8 awake read", d, 32'h0);
        bus_write(OFF_WAKE, 32'h2, 1'b1);
        check("R8 asleep again", 32'(core_asleep), 32'd1);
    endtask

    task automatic t_ppi();
        bus_write(OFF_PND_CLR, 32'hFFFF_FFFF, 1'b1);
        check("R9 cleared", out_pending, 32'h0);
        @(negedge clk);
        ppi_assert = 16'h0008;
        @(negedge clk);
        ppi_assert = '0;
        check("R9 ppi pends", out_pending, 32'h0008_0000);
        @(negedge clk);
        ppi_assert = 16'h0008;
        req_valid = 1'b1; req_write = 1'b1; req_addr = OFF_PND_CLR;
        req_wdata = 32'h0008_0000; req_secure = 1'b1;
        @(negedge clk);
        ppi_assert = '0; req_valid = 1'b0; req_write = 1'b0;
        check("R9 ppi beats clear", out_pending, 32'h0008_0000);
        bus_write(OFF_PND_CLR, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_sgi();
        send_sgi(4'd2, 1'b1, 1'b0);
        check("R10 group match", out_pending, 32'h0000_0004);
        send_sgi(4'd5, 1'b1, 1'b0);
        check("R10 mismatch dropped", out_pending, 32'h0000_0004);
        send_sgi(4'd5, 1'b1, 1'b1);
        check("R10 ns no access", out_pending, 32'h0000_0004);
        bus_write(OFF_NSACC, 32'h0000_0400, 1'b1);
        send_sgi(4'd5, 1'b1, 1'b1);
        check("R10 ns access", out_pending, 32'h0000_0024);
        send_sgi(4'd6, 1'b0, 1'b1);
        check("R10 group0 match", out_pending, 32'h0000_0064);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_write(5'd31, 32'hFFFF_FFFF, 1'b1);
        check("R11 no rsp on write", 32'(rsp_valid), 32'd0);
        bus_read(5'd31, 1'b1, d);
        check("R11 unmapped read", d, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_setclr();
        t_prio();
        t_group();
        t_secure_only();
        t_trigger();
        t_wake();
        t_ppi();
        t_sgi();
        t_unmapped();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule